// File: doc/BRIEF.md
# Programmable Wide Product-Term Decoder

This block is a bank of four configurable wide AND gates that all look at one shared 12-bit input bus. The bus is organised as four groups of three signals. For every decoder and every input, a 2-bit selection code says whether that input takes part in the product, and in which polarity: true sense, complement, or not at all. Each decoder thus forms one product term of the kind found in a programmable-array-logic device. An empty product, with no input selected, is true.

Any decoder can be split into two independent half-width product terms. The low half covers inputs 0 to 5 and the high half covers inputs 6 to 11. An OR stage with a per-term enable mask merges any chosen subset of the eight term outputs into one sum-of-products result. Selection codes, split flags and the OR mask are held in registers that are loaded through a synchronous write port. The path from the input bus to the outputs has no register in it.

Top module: `wd_wide_decoder`

## Requirements
- R1: Each input of each decoder has a 2-bit code. Code 00 ignores the input, 01 uses it in true sense and 10 uses it complemented. The code for input g*3+k of decoder d is written at address d*4+g, in data bits [2k+1:2k].
- R2: Code 11 is reserved and acts exactly like 00: the input has no effect on the term.
- R3: A product term with no input selected by code 01 or 10 outputs 1.
- R4: When decoder d is not split, term_o[2d] is the AND of all twelve of its literals and term_o[2d+1] is 0.
- R5: When decoder d is split, term_o[2d] is the AND of its literals on inputs 0 to 5 and term_o[2d+1] is the AND of its literals on inputs 6 to 11.
- R6: The four decoders read the same in_bus, each through its own codes, and their results do not affect one another.
- R7: sop_o is the OR of the term_o bits whose bit is set in the OR mask, written at address 17 with bit j selecting term_o[j]. An all-zero mask gives sop_o = 0.
- R8: The split flags are written at address 16, with bit d splitting decoder d. Changing a flag switches that decoder between the R4 and R5 behaviour.
- R9: term_o and sop_o follow in_bus combinationally, with no clock edge needed.
- R10: A write takes effect on the rising clock edge where wr_en is high. With wr_en low, or with an address above 17, the stored configuration stays unchanged.
- R11: While rst_n is low, all codes, split flags and mask bits are cleared, which gives term_o = 8'h55 and sop_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 5 | Configuration word address |
| wr_data | input | 8 | Configuration word data |
| in_bus | input | 12 | Shared decoder input bus |
| term_o | output | 8 | Product-term outputs, two per decoder |
| sop_o | output | 1 | Masked OR of the product terms |

## Verification
A fixed mix of configurations drives one table of bus patterns: one unsplit decoder with true and complemented literals, two split decoders (one of them with a reserved code and one with an empty low half), and one fully empty decoder. The all-zero and all-one patterns tell true-sense literals apart from complemented ones. Patterns that set one literal at a time show which half of a split decoder each input reaches, and toggling the reserved-code input alone shows that it has no effect. Clearing a split flag under the same bus pattern separates the half-width AND from the full-width AND. Mask changes with fixed terms isolate the OR stage.

// File: rtl/wd_pkg.sv
`timescale 1ns/1ps
package wd_pkg;

    typedef enum logic [1:0] {
        LIT_IGNORE = 2'b00,
        LIT_TRUE   = 2'b01,
        LIT_INVERT = 2'b10,
        LIT_RSVD   = 2'b11
    } lit_code_e;

    // A literal passes (evaluates to 1) when it is satisfied or not selected.
    function automatic logic lit_pass(input logic [1:0] code, input logic x);
        logic r;
        case (lit_code_e'(code))
            LIT_TRUE:   r = x;
            LIT_INVERT: r = ~x;
            default:    r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wd_cfg_regs.sv
`timescale 1ns/1ps
module wd_cfg_regs #(
    parameter int N_GROUPS       = 4,
    parameter int VARS_PER_GROUP = 3,
    parameter int N_DEC          = 4,
    parameter int ADDR_W         = 5,
    parameter int DATA_W         = 8
) (
    input  logic                                                  clk,
    input  logic                                                  rst_n,
    input  logic                                                  wr_en,
    input  logic [ADDR_W-1:0]                                     wr_addr,
    input  logic [DATA_W-1:0]                                     wr_data,
    output logic [N_DEC-1:0][N_GROUPS*VARS_PER_GROUP-1:0][1:0]    cfg_o,
    output logic [N_DEC-1:0]                                      split_o,
    output logic [2*N_DEC-1:0]                                    mask_o
);
    localparam int N_IN       = N_GROUPS * VARS_PER_GROUP;
    localparam int N_TERM     = 2 * N_DEC;
    localparam int CFG_WORDS  = N_DEC * N_GROUPS;
    localparam int ADDR_SPLIT = CFG_WORDS;
    localparam int ADDR_MASK  = CFG_WORDS + 1;

    typedef struct packed {
        logic [N_DEC-1:0][N_IN-1:0][1:0] cfg;
        logic [N_DEC-1:0]                split;
        logic [N_TERM-1:0]               mask;
    } regs_t;

    regs_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            for (int d = 0; d < N_DEC; d++) begin
                for (int g = 0; g < N_GROUPS; g++) begin
                    if (wr_addr == ADDR_W'(d * N_GROUPS + g)) begin
                        for (int k = 0; k < VARS_PER_GROUP; k++) begin
                            state_d.cfg[d][g*VARS_PER_GROUP+k] = wr_data[2*k +: 2];
                        end
                    end
                end
            end
            if (wr_addr == ADDR_W'(ADDR_SPLIT)) begin
                state_d.split = wr_data[N_DEC-1:0];
            end
            if (wr_addr == ADDR_W'(ADDR_MASK)) begin
                state_d.mask = wr_data[N_TERM-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cfg_o   = state_q.cfg;
    assign split_o = state_q.split;
    assign mask_o  = state_q.mask;

endmodule

// File: rtl/wd_product_term.sv
`timescale 1ns/1ps
module wd_product_term #(
    parameter int N_IN = 12
) (
    input  logic [N_IN-1:0]      in_bus,
    input  logic [N_IN-1:0][1:0] cfg,
    input  logic                 split,
    output logic                 lo_o,
    output logic                 hi_o
);
    import wd_pkg::*;

    localparam int LO_W = N_IN / 2;

    logic [N_IN-1:0] pass;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign pass[i] = lit_pass(cfg[i], in_bus[i]);
    end

    logic lo_all, hi_all;
    assign lo_all = &pass[LO_W-1:0];
    assign hi_all = &pass[N_IN-1:LO_W];

    assign lo_o = split ? lo_all : (lo_all & hi_all);
    assign hi_o = split & hi_all;

endmodule

// File: rtl/wd_sum_stage.sv
`timescale 1ns/1ps
module wd_sum_stage #(
    parameter int N_TERM = 8
) (
    input  logic [N_TERM-1:0] terms,
    input  logic [N_TERM-1:0] mask,
    output logic              sop_o
);
    assign sop_o = |(terms & mask);
endmodule

// File: rtl/wd_wide_decoder.sv
`timescale 1ns/1ps
module wd_wide_decoder #(
    parameter  int N_GROUPS       = 4,
    parameter  int VARS_PER_GROUP = 3,
    parameter  int N_DEC          = 4,
    localparam int N_IN           = N_GROUPS * VARS_PER_GROUP,
    localparam int N_TERM         = 2 * N_DEC,
    localparam int ADDR_W         = $clog2(N_DEC * N_GROUPS + 2),
    localparam int DATA_W         = (2 * VARS_PER_GROUP > N_TERM) ? 2 * VARS_PER_GROUP : N_TERM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [N_IN-1:0]   in_bus,
    output logic [N_TERM-1:0] term_o,
    output logic              sop_o
);
    logic [N_DEC-1:0][N_IN-1:0][1:0] cfg_q;
    logic [N_DEC-1:0]                split_q;
    logic [N_TERM-1:0]               mask_q;

    wd_cfg_regs #(
        .N_GROUPS       (N_GROUPS),
        .VARS_PER_GROUP (VARS_PER_GROUP),
        .N_DEC          (N_DEC),
        .ADDR_W         (ADDR_W),
        .DATA_W         (DATA_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_o   (cfg_q),
        .split_o (split_q),
        .mask_o  (mask_q)
    );

    for (genvar d = 0; d < N_DEC; d++) begin : g_dec
        wd_product_term #(
            .N_IN (N_IN)
        ) u_term (
            .in_bus (in_bus),
            .cfg    (cfg_q[d]),
            .split  (split_q[d]),
            .lo_o   (term_o[2*d]),
            .hi_o   (term_o[2*d+1])
        );
    end

    wd_sum_stage #(
        .N_TERM (N_TERM)
    ) u_sum (
        .terms (term_o),
        .mask  (mask_q),
        .sop_o (sop_o)
    );

endmodule

// File: rtl/wd_decoder_chk.sv
`timescale 1ns/1ps
module wd_decoder_chk #(
    parameter  int N_GROUPS       = 4,
    parameter  int VARS_PER_GROUP = 3,
    parameter  int N_DEC          = 4,
    localparam int N_IN           = N_GROUPS * VARS_PER_GROUP,
    localparam int N_TERM         = 2 * N_DEC,
    localparam int ADDR_W         = $clog2(N_DEC * N_GROUPS + 2),
    localparam int LAST_ADDR      = N_DEC * N_GROUPS + 1
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic [ADDR_W-1:0]               wr_addr,
    input logic [N_DEC-1:0][N_IN-1:0][1:0] cfg_q,
    input logic [N_DEC-1:0]                split_q,
    input logic [N_TERM-1:0]               mask_q,
    input logic [N_TERM-1:0]               term_o,
    input logic                            sop_o
);
    // R10: nothing written while the strobe is low
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(cfg_q) && $stable(split_q) && $stable(mask_q)));

    // R10: addresses beyond the map leave the configuration alone
    a_r10_bad_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr > ADDR_W'(LAST_ADDR)))
        |=> ($stable(cfg_q) && $stable(split_q) && $stable(mask_q)));

    // R7: an empty mask keeps the sum low
    a_r7_zero_mask_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !sop_o);

    // R7: a high sum needs at least one enabled high term
    a_r7_sop_needs_term: assert property (@(posedge clk) disable iff (!rst_n)
        sop_o |-> ((term_o & mask_q) != '0));

    for (genvar d = 0; d < N_DEC; d++) begin : g_chk
        logic no_sel;
        always_comb begin
            no_sel = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                if (cfg_q[d][i][0] != cfg_q[d][i][1]) no_sel = 1'b0;
            end
        end

        // R4: an unsplit decoder keeps its upper output low
        a_r4_hi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !split_q[d] |-> !term_o[2*d+1]);

        // R3: with nothing selected the term is true
        a_r3_empty_true: assert property (@(posedge clk) disable iff (!rst_n)
            no_sel |-> term_o[2*d]);

        // R5: a split decoder with nothing selected drives both halves high
        a_r5_split_empty: assert property (@(posedge clk) disable iff (!rst_n)
            (no_sel && split_q[d]) |-> term_o[2*d+1]);
    end
endmodule

bind wd_wide_decoder wd_decoder_chk #(
    .N_GROUPS       (N_GROUPS),
    .VARS_PER_GROUP (VARS_PER_GROUP),
    .N_DEC          (N_DEC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cfg_q   (cfg_q),
    .split_q (split_q),
    .mask_q  (mask_q),
    .term_o  (term_o),
    .sop_o   (sop_o)
);

// File: tb/wd_wide_decoder_tb.sv
`timescale 1ns/1ps
module wd_wide_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [11:0] in_bus = '0;
    logic [7:0]  term_o;
    logic        sop_o;

    int n_cmp = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wd_wide_decoder u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .in_bus  (in_bus),
        .term_o  (term_o),
        .sop_o   (sop_o)
    );

    // {in_bus, expected term_o, expected sop_o} under the reference configuration
    localparam logic [20:0] VECS [0:6] = '{
        {12'h000, 8'h58, 1'b1},
        {12'hFFF, 8'h54, 1'b0},
        {12'h841, 8'h51, 1'b1},
        {12'h246, 8'hD4, 1'b1},
        {12'h8E1, 8'h50, 1'b0},
        {12'h080, 8'h58, 1'b1},
        {12'h600, 8'h58, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic drive_and_sample(input logic [11:0] v);
        @(negedge clk);
        in_bus = v;
        #1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // Reset state
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset terms", term_o, 8'h55);
        check("R11 reset sop", sop_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Empty products stay true whatever the bus holds
        drive_and_sample(12'hA5C);
        check("R3 empty terms", term_o, 8'h55);

        // Strobe low: no write
        @(negedge clk);
        wr_addr = 5'd17;
        wr_data = 8'hFF;
        @(posedge clk);
        #1;
        check("R10 strobe low sop", sop_o, 1'b0);
        // Out-of-range addresses
        cfg_write(5'd20, 8'hFF);
        cfg_write(5'd31, 8'hFF);
        check("R10 bad addr sop", sop_o, 1'b0);
        check("R10 bad addr terms", term_o, 8'h55);

        // Write becomes visible only after the edge
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 5'd17;
        wr_data = 8'h10;
        #1;
        check("R10 before edge sop", sop_o, 1'b0);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        check("R10 after edge sop", sop_o, 1'b1);

        // Reference configuration
        cfg_write(5'd0,  8'h01);  // d0: in0 true
        cfg_write(5'd1,  8'h20);  // d0: in5 complement
        cfg_write(5'd3,  8'h10);  // d0: in11 true
        cfg_write(5'd4,  8'h14);  // d1: in1, in2 true
        cfg_write(5'd6,  8'h0E);  // d1: in6 complement, in7 reserved
        cfg_write(5'd15, 8'h09);  // d3: in9 true, in10 complement
        cfg_write(5'd16, 8'h0A);  // split d1 and d3
        cfg_write(5'd17, 8'h89);  // OR terms 0, 3, 7

        // Table walk: R1 R4 R5 R6 on terms, R7 on the sum
        for (int i = 0; i < 7; i++) begin
            drive_and_sample(VECS[i][20:9]);
            check("R1 R4 R5 R6 table terms", term_o, VECS[i][8:1]);
            check("R7 table sop", sop_o, VECS[i][0]);
        end

        // Reserved code: input 7 alone has no effect
        drive_and_sample(12'h0C0);
        check("R2 reserved with in6", term_o, 8'h50);
        drive_and_sample(12'h040);
        check("R2 reserved without in7", term_o, 8'h50);

        // Combinational path: two bus changes inside one clock phase
        @(negedge clk);
        in_bus = 12'h000;
        #0.5;
        check("R9 comb first", term_o, 8'h58);
        in_bus = 12'hFFF;
        #0.5;
        check("R9 comb second", term_o, 8'h54);

        // Unsplit d3: full AND of both halves
        cfg_write(5'd16, 8'h02);
        drive_and_sample(12'h200);
        check("R8 R4 unsplit d3 true", term_o, 8'h58);
        drive_and_sample(12'h600);
        check("R8 R4 unsplit d3 false", term_o, 8'h18);

        // Mask behaviour with fixed terms (0x18 at bus 0)
        drive_and_sample(12'h000);
        cfg_write(5'd17, 8'h00);
        check("R7 zero mask", sop_o, 1'b0);
        cfg_write(5'd17, 8'h80);
        check("R7 mask low term", sop_o, 1'b0);
        cfg_write(5'd17, 8'h08);
        check("R7 mask high term", sop_o, 1'b1);

        // Reset in mid-operation
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R11 async reset terms", term_o, 8'h55);
        check("R11 async reset sop", sop_o, 1'b0);

        done = 1'b1;
        finish_run();
    end

endmodule